// File: doc/BRIEF.md
# Video Memory Block Copy DMA Engine

This engine moves a run of bytes from one place in video memory to another without passing them through the write queue. A copy is armed by a one-cycle load strobe that captures the source address bytes, the transfer length, the destination address and the command code. The engine then works only on external access slots. A slot is one cycle with `slot_i` high. The engine may use a slot only when no queued write is pending and its stored source-high byte selects copy mode.

Each byte takes two granted slots. In the first slot the engine reads the source byte into a holding register. In the next slot it writes that byte to the destination. Both memory addresses are presented with bit 0 inverted, which swaps the byte lane. After every write the engine updates its registers in place and drives them as outputs, so software can watch the progress. When the length runs out, the engine stops and raises a one-cycle done event.

The memory port is a plain strobe interface with no back-pressure. A granted slot is itself the permission to access memory. Read data must be valid combinationally in the same cycle as `rd_en_o`. The engine never stalls and never retries.

Top module: `vram_copy_dma`

## Requirements
- R1: While reset is asserted, and after its release, `busy_o`, `done_o`, `rd_en_o` and `wr_en_o` are all low.
- R2: The engine touches memory only when it is running and bits 7:6 of the stored source-high byte are 2'b11. Any other mode leaves both memory strobes low and all registers unchanged.
- R3: On a granted slot with no byte held, the engine reads at address {source_mid, source_low} XOR 16'h0001. It stores `rd_data_i` and does not write in that cycle.
- R4: On the next granted slot, the engine writes the held byte to destination XOR 16'h0001 and does not read in that cycle.
- R5: After each write, source_low increments. When source_low wraps from 8'hFF, source_mid increments. Source_high never changes.
- R6: After each write, the 8-bit auto-increment value (zero-extended, modulo 2^16) is added to the destination, and the 16-bit length decrements.
- R7: The write that brings the length to zero stops the engine. It also clears bits 5:4 of the 6-bit command code. `done_o` is high for exactly the following cycle, and `busy_o` is low from then on.
- R8: A slot that arrives while `fifo_pend_i` is high is skipped. There is no memory access and no state change.
- R9: A load strobe discards any held byte and takes priority over a slot in the same cycle. That cycle has no access, and the next granted slot is a read at the newly loaded source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Load strobe that arms a transfer |
| src_hi_i | input | 8 | Source-high byte; bits 7:6 select the mode |
| src_mid_i | input | 8 | Source middle byte |
| src_lo_i | input | 8 | Source low byte |
| len_i | input | 16 | Transfer length in bytes |
| dst_i | input | 16 | Destination address |
| cd_i | input | 6 | Command code |
| autoinc_i | input | 8 | Destination step, sampled live |
| slot_i | input | 1 | External access slot strobe |
| fifo_pend_i | input | 1 | A queued write owns this slot |
| rd_en_o | output | 1 | Memory read strobe |
| rd_addr_o | output | 16 | Memory read address |
| rd_data_i | input | 8 | Memory read data (same cycle) |
| wr_en_o | output | 1 | Memory write strobe |
| wr_addr_o | output | 16 | Memory write address |
| wr_data_o | output | 8 | Memory write data |
| src_hi_o | output | 8 | Current source-high byte |
| src_mid_o | output | 8 | Current source middle byte |
| src_lo_o | output | 8 | Current source low byte |
| len_o | output | 16 | Remaining length |
| dst_o | output | 16 | Current destination |
| cd_o | output | 6 | Current command code |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | One-cycle completion event |

## Verification
Two functions can land in the same cycle. The first pair is a load strobe and a slot: the bench raises `start_i` and `slot_i` together right after a read has filled the holding register. It then expects no access in that cycle and a read, not a write, at the new source on the next slot. The second pair is a slot and a pending queued write: the bench raises both together and judges from the ports that nothing was accessed, that the source and length did not move, and that the following free slot continues the same read-or-write step.

// File: rtl/vcopy_pkg.sv
package vcopy_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;

  function automatic logic [ADDR_W-1:0] lane_swap(input logic [ADDR_W-1:0] a);
    return a ^ {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/vcopy_src_ctr.sv
module vcopy_src_ctr #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] ld_hi,
  input  logic [BYTE_W-1:0] ld_mid,
  input  logic [BYTE_W-1:0] ld_lo,
  input  logic              step,
  output logic [BYTE_W-1:0] hi_o,
  output logic [BYTE_W-1:0] mid_o,
  output logic [BYTE_W-1:0] lo_o
);
  localparam logic [BYTE_W-1:0] ONES = '1;
  localparam logic [BYTE_W-1:0] ONE  = BYTE_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_o  <= '0;
      mid_o <= '0;
      lo_o  <= '0;
    end else if (load) begin
      hi_o  <= ld_hi;
      mid_o <= ld_mid;
      lo_o  <= ld_lo;
    end else if (step) begin
      lo_o <= lo_o + ONE;
      if (lo_o == ONES) mid_o <= mid_o + ONE;
    end
  end

  // R5: carry goes from the low byte into the middle byte only
  assert_src_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && lo_o == ONES) |=> (mid_o == $past(mid_o) + ONE && lo_o == '0));
  assert_src_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && lo_o != ONES) |=> (mid_o == $past(mid_o)));
endmodule

// File: rtl/vcopy_len_ctr.sv
module vcopy_len_ctr #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] ld_val,
  input  logic             step,
  output logic [LEN_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_o <= '0;
    else if (load)   cnt_o <= ld_val;
    else if (step)   cnt_o <= cnt_o - ONE;
  end

  assign last_o = (cnt_o == ONE);

  // R6: each write takes exactly one off the length
  assert_len_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cnt_o == $past(cnt_o) - ONE));
endmodule

// File: rtl/vcopy_dst_ctr.sv
module vcopy_dst_ctr #(
  parameter int ADDR_W = 16,
  parameter int INC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              step,
  input  logic [INC_W-1:0]  inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      addr_o <= '0;
    else if (load)   addr_o <= ld_val;
    else if (step)   addr_o <= addr_o + ADDR_W'(inc_i);
  end

  // R6: destination advances by the live step value
  assert_dst_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (addr_o == $past(addr_o) + ADDR_W'($past(inc_i))));
endmodule

// File: rtl/vram_copy_dma.sv
module vram_copy_dma
  import vcopy_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int CD_W    = 6,
  parameter int CD_KEEP = 4,
  parameter int INC_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] src_hi_i,
  input  logic [BYTE_W-1:0] src_mid_i,
  input  logic [BYTE_W-1:0] src_lo_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [CD_W-1:0]   cd_i,
  input  logic [INC_W-1:0]  autoinc_i,
  input  logic              slot_i,
  input  logic              fifo_pend_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [BYTE_W-1:0] src_hi_o,
  output logic [BYTE_W-1:0] src_mid_o,
  output logic [BYTE_W-1:0] src_lo_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CD_W-1:0]   cd_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [CD_W-1:0] CD_MASK = {{(CD_W-CD_KEEP){1'b0}}, {CD_KEEP{1'b1}}};
  localparam logic [1:0]      MODE_COPY = 2'b11;

  logic              run_q, fetched_q, done_q;
  logic [BYTE_W-1:0] hold_q;
  logic [CD_W-1:0]   cd_q;
  logic              len_last;
  logic              copy_mode, grant;

  vcopy_src_ctr #(.BYTE_W(BYTE_W)) u_src (
    .clk(clk), .rst_n(rst_n), .load(start_i),
    .ld_hi(src_hi_i), .ld_mid(src_mid_i), .ld_lo(src_lo_i),
    .step(wr_en_o), .hi_o(src_hi_o), .mid_o(src_mid_o), .lo_o(src_lo_o)
  );

  vcopy_len_ctr #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .load(start_i), .ld_val(len_i),
    .step(wr_en_o), .cnt_o(len_o), .last_o(len_last)
  );

  vcopy_dst_ctr #(.ADDR_W(ADDR_W), .INC_W(INC_W)) u_dst (
    .clk(clk), .rst_n(rst_n), .load(start_i), .ld_val(dst_i),
    .step(wr_en_o), .inc_i(autoinc_i), .addr_o(dst_o)
  );

  assign copy_mode = (src_hi_o[BYTE_W-1 -: 2] == MODE_COPY);
  assign busy_o    = run_q && copy_mode;
  assign grant     = slot_i && !fifo_pend_i && busy_o && !start_i;
  assign rd_en_o   = grant && !fetched_q;
  assign wr_en_o   = grant && fetched_q;
  assign rd_addr_o = lane_swap({src_mid_o, src_lo_o});
  assign wr_addr_o = lane_swap(dst_o);
  assign wr_data_o = hold_q;
  assign cd_o      = cd_q;
  assign done_o    = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      fetched_q <= 1'b0;
      hold_q    <= '0;
      cd_q      <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= wr_en_o && len_last;
      if (start_i) begin
        run_q     <= 1'b1;
        fetched_q <= 1'b0;
        cd_q      <= cd_i;
      end else if (rd_en_o) begin
        hold_q    <= rd_data_i;
        fetched_q <= 1'b1;
      end else if (wr_en_o) begin
        fetched_q <= 1'b0;
        if (len_last) begin
          run_q <= 1'b0;
          cd_q  <= cd_q & CD_MASK;
        end
      end
    end
  end

  // R1: quiet from reset
  assert_quiet_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (!busy_o && !done_o && !rd_en_o && !wr_en_o));
  // R2: memory is only touched in copy mode on a real slot
  assert_mode_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_o || wr_en_o) |-> (slot_i && src_hi_o[BYTE_W-1 -: 2] == MODE_COPY));
  // R3: the read byte is what the next write carries
  assert_hold_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |=> (wr_data_o == $past(rd_data_i)));
  // R4: read and write never share a slot
  assert_one_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en_o && wr_en_o));
  // R5: source-high never moves during a copy step
  assert_src_hi_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> (src_hi_o == $past(src_hi_o) && src_lo_o == $past(src_lo_o) + 8'd1));
  // R7: completion stops the engine and trims the command code
  assert_done_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && (cd_o & ~CD_MASK) == '0 && len_o == '0));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R8: a pending queued write owns the slot
  assert_fifo_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pend_i |-> (!rd_en_o && !wr_en_o));
  // R9: a load cycle never accesses memory
  assert_load_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (!rd_en_o && !wr_en_o));
endmodule

// File: tb/test_vram_copy_dma.sv
module test_vram_copy_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  src_hi_i = '0, src_mid_i = '0, src_lo_i = '0;
  logic [15:0] len_i = '0, dst_i = '0;
  logic [5:0]  cd_i = '0;
  logic [7:0]  autoinc_i = '0;
  logic        slot_i = 1'b0, fifo_pend_i = 1'b0;
  logic        rd_en_o, wr_en_o, busy_o, done_o;
  logic [15:0] rd_addr_o, wr_addr_o, len_o, dst_o;
  logic [7:0]  rd_data_i, wr_data_o, src_hi_o, src_mid_o, src_lo_o;
  logic [5:0]  cd_o;

  int checks = 0;
  int errors = 0;

  // captured per slot
  logic        c_rd, c_wr;
  logic [15:0] c_rda, c_wra;
  logic [7:0]  c_wrd;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign rd_data_i = mem_byte(rd_addr_o);

  vram_copy_dma i_vram_copy_dma (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .src_hi_i(src_hi_i), .src_mid_i(src_mid_i), .src_lo_i(src_lo_i),
    .len_i(len_i), .dst_i(dst_i), .cd_i(cd_i), .autoinc_i(autoinc_i),
    .slot_i(slot_i), .fifo_pend_i(fifo_pend_i),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .src_hi_o(src_hi_o), .src_mid_o(src_mid_o), .src_lo_o(src_lo_o),
    .len_o(len_o), .dst_o(dst_o), .cd_o(cd_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // call at a negedge; returns at the following negedge
  task automatic load(input logic [7:0] hi, input logic [7:0] mid, input logic [7:0] lo,
                      input logic [15:0] len, input logic [15:0] dst, input logic [7:0] inc,
                      input bit with_slot);
    start_i = 1'b1; src_hi_i = hi; src_mid_i = mid; src_lo_i = lo;
    len_i = len; dst_i = dst; cd_i = 6'h21; autoinc_i = inc; slot_i = with_slot;
    #1;
    c_rd = rd_en_o; c_wr = wr_en_o;
    @(negedge clk);
    start_i = 1'b0; slot_i = 1'b0;
  endtask

  task automatic slot(input bit pend);
    slot_i = 1'b1; fifo_pend_i = pend;
    #1;
    c_rd = rd_en_o; c_wr = wr_en_o; c_rda = rd_addr_o; c_wra = wr_addr_o; c_wrd = wr_data_o;
    @(negedge clk);
    slot_i = 1'b0; fifo_pend_i = 1'b0;
  endtask

  // {mid, lo, len, dst, inc}
  localparam logic [55:0] VEC [4] = '{
    {8'h10, 8'h20, 16'd4, 16'h0100, 8'd1},
    {8'h33, 8'hFE, 16'd3, 16'h2000, 8'd2},
    {8'h7F, 8'hFF, 16'd2, 16'hFFFE, 8'd4},
    {8'h00, 8'h05, 16'd1, 16'h1234, 8'd0}
  };

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !rd_en_o && !wr_en_o, "R1 reset quiet",
          {busy_o, done_o, rd_en_o, wr_en_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o, "R1 after release", {busy_o, done_o}, 0);

    // table walk: R3 R4 R5 R6 R7
    foreach (VEC[v]) begin
      logic [7:0]  mid, lo;
      logic [15:0] len, dst;
      logic [7:0]  inc;
      {mid, lo, len, dst, inc} = VEC[v];
      load(8'hC5, mid, lo, len, dst, inc, 1'b0);
      check(busy_o, "R2 copy mode busy", busy_o, 1);
      for (int b = 0; b < int'(len); b++) begin
        logic [15:0] ra;
        ra = {mid, lo} ^ 16'h0001;
        slot(1'b0);
        check(c_rd && !c_wr && c_rda == ra, "R3 read slot", {c_rd, c_wr, c_rda}, {2'b10, ra});
        slot(1'b0);
        check(c_wr && !c_rd && c_wra == (dst ^ 16'h0001) && c_wrd == mem_byte(ra),
              "R4 write slot", {c_wr, c_rd, c_wra, c_wrd}, {2'b10, dst ^ 16'h0001, mem_byte(ra)});
        if (lo == 8'hFF) mid = mid + 8'd1;
        lo  = lo + 8'd1;
        dst = dst + {8'h00, inc};
      end
      check(done_o && !busy_o, "R7 done pulse", {done_o, busy_o}, 2'b10);
      check(src_hi_o == 8'hC5 && src_mid_o == mid && src_lo_o == lo, "R5 source regs",
            {src_hi_o, src_mid_o, src_lo_o}, {8'hC5, mid, lo});
      check(dst_o == dst && len_o == 16'd0, "R6 dest and length", {dst_o, len_o}, {dst, 16'd0});
      check(cd_o == 6'h01, "R7 command code trimmed", cd_o, 6'h01);
      @(negedge clk);
      check(!done_o, "R7 done single cycle", done_o, 0);
    end

    // R2: other mode never touches memory
    load(8'h80, 8'h11, 8'h22, 16'd2, 16'h0400, 8'd1, 1'b0);
    slot(1'b0);
    check(!c_rd && !c_wr && !busy_o, "R2 non-copy mode idle", {c_rd, c_wr, busy_o}, 0);
    slot(1'b0);
    check(len_o == 16'd2 && src_lo_o == 8'h22 && dst_o == 16'h0400, "R2 regs unchanged",
          {len_o, src_lo_o}, {16'd2, 8'h22});

    // R8: pending queued write takes the slot
    load(8'hC0, 8'h40, 8'h00, 16'd2, 16'h0300, 8'd1, 1'b0);
    slot(1'b1);
    check(!c_rd && !c_wr, "R8 pend skips read", {c_rd, c_wr}, 0);
    check(len_o == 16'd2 && src_lo_o == 8'h00, "R8 no state change", {len_o, src_lo_o}, {16'd2, 8'h00});
    slot(1'b0);
    check(c_rd && c_rda == 16'h4001, "R8 read after pend", {c_rd, c_rda}, {1'b1, 16'h4001});
    slot(1'b1);
    check(!c_rd && !c_wr, "R8 pend skips write", {c_rd, c_wr}, 0);
    slot(1'b0);
    check(c_wr && c_wra == 16'h0301 && c_wrd == mem_byte(16'h4001), "R8 write after pend",
          {c_wr, c_wra, c_wrd}, {1'b1, 16'h0301, mem_byte(16'h4001)});

    // R9: reload after a read, together with a slot
    slot(1'b0);
    check(c_rd, "R9 byte held before reload", c_rd, 1);
    load(8'hC0, 8'h50, 8'h10, 16'd1, 16'h0600, 8'd1, 1'b1);
    check(!c_rd && !c_wr, "R9 load wins over slot", {c_rd, c_wr}, 0);
    slot(1'b0);
    check(c_rd && !c_wr && c_rda == 16'h5011, "R9 held byte dropped", {c_rd, c_wr, c_rda}, {2'b10, 16'h5011});
    slot(1'b0);
    check(c_wr && c_wra == 16'h0601 && c_wrd == mem_byte(16'h5011), "R9 write new data",
          {c_wr, c_wra, c_wrd}, {1'b1, 16'h0601, mem_byte(16'h5011)});
    check(done_o, "R7 done after reload copy", done_o, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule